// File: doc/BRIEF.md
# Context Stacking Sequencer

This block saves and restores processor context on a byte-wide stack held in an external single-port memory. It owns a stack pointer that always points at the next free byte. The stack grows toward lower addresses. A command from the sequencing logic starts a transfer of one to nine bytes. The block then issues one memory access per granted clock cycle and raises a one-cycle completion pulse when the last byte is done.

It covers several kinds of command. A subroutine call saves a 2-byte return address, and a subroutine return restores it. Interrupt entry saves a nine-byte frame, and the return from an interrupt restores that frame in exactly the reverse byte order. Single-register saves and restores move one accumulator or one index register. A wait command saves the full frame ahead of time and then parks until an interrupt request arrives. At that point it raises completion together with a vector-request pulse and writes nothing more.

Register values enter on dedicated inputs and are captured when a command is accepted. Restored values appear on dedicated outputs. Those outputs change only when a restore has finished in full, so a partly restored context is never visible.

Top module: `ctx_stack_seq`

## Requirements
- R1: Call-save (code 1) writes the low byte of `ret_addr_in` at address SP, then the high byte at SP-1, and leaves SP two lower than before.
- R2: Call-restore (code 2) reads the high byte at SP+1, then the low byte at SP+2, presents them on `ret_addr_out`, and leaves SP two higher than before.
- R3: Interrupt-save (code 3) writes nine bytes at SP, SP-1, … SP-8 in this order: return low, return high, IY low, IY high, IX low, IX high, A, B, CCR. It leaves SP nine lower and pulses `vec_req` together with `done`.
- R4: Interrupt-restore (code 4) reads nine bytes at SP+1 … SP+9 in the exact reverse of the R3 order (CCR first, return low last), restores all six register outputs, and leaves SP nine higher.
- R5: Single saves write A (code 6) or B (code 7) as one byte, and X (code 8) or Y (code 9) as the low byte at SP followed by the high byte at SP-1. The matching restores (codes 10, 11, 12, 13) read in the reverse order and update only that register's output.
- R6: One access completes in each cycle where `mem_req` and `mem_gnt` are both high. While the grant is low, the request, the address and SP hold steady.
- R7: `busy` is high from the cycle after a command is accepted until the transfer ends. Commands presented while `busy` is high are ignored.
- R8: Wait (code 5) performs the R3 nine-byte save and then stays busy without `done`. The first cycle with `irq` high then yields `done` and `vec_req` together in the next cycle, with no further memory access.
- R9: The restored register outputs stay unchanged throughout a restore and update only in the cycle that `done` rises.
- R10: SP resets to the parameter `RESET_SP` and wraps modulo 2^ADDR_W in both directions without any error indication.
- R11: `done` is a single-cycle pulse in the cycle after the last granted byte. `vec_req` is high only with `done` after an interrupt-save or a wait wake-up.
- R12: Codes 0, 14 and 15 are not commands. They start no access and leave SP and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 4 | Command code (see R1–R12 encodings) |
| ret_addr_in | input | 16 | Return address to save |
| ix_in | input | 16 | X index register to save |
| iy_in | input | 16 | Y index register to save |
| acca_in | input | 8 | Accumulator A to save |
| accb_in | input | 8 | Accumulator B to save |
| ccr_in | input | 8 | Condition code register to save |
| irq | input | 1 | Interrupt request that ends a wait |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable (1 for writes) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the granted cycle |
| mem_gnt | input | 1 | Memory grant; access completes in this cycle |
| busy | output | 1 | Transfer or wait in progress |
| done | output | 1 | Completion pulse |
| vec_req | output | 1 | Vector fetch request pulse |
| sp_out | output | ADDR_W | Current stack pointer |
| ret_addr_out | output | 16 | Restored return address |
| ix_out | output | 16 | Restored X |
| iy_out | output | 16 | Restored Y |
| acca_out | output | 8 | Restored A |
| accb_out | output | 8 | Restored B |
| ccr_out | output | 8 | Restored condition codes |

## Verification
The bench builds two instances. The first keeps the default `RESET_SP` of 16'h00FF, so every frame sits low in the address space. There, byte order, stalled grants, restore visibility and the wait state are checked against a bench memory model. The second uses `RESET_SP` = 16'h0001, so a call-save and an interrupt-save carry SP through zero into the top of the address space. The matching restores must then bring SP and the return address back across that same boundary.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 2 * BYTE_W;
    localparam int FRAME_BYTES = 9;
    localparam int SLOT_W      = $clog2(FRAME_BYTES + 1);

    // frame slot numbering = order of bytes in a full save
    localparam logic [SLOT_W-1:0] SL_RET_LO = 4'd0;
    localparam logic [SLOT_W-1:0] SL_IY_LO  = 4'd2;
    localparam logic [SLOT_W-1:0] SL_IX_LO  = 4'd4;
    localparam logic [SLOT_W-1:0] SL_A      = 4'd6;
    localparam logic [SLOT_W-1:0] SL_B      = 4'd7;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,  OP_CALL = 4'd1,  OP_RETS = 4'd2,  OP_INTR = 4'd3,
        OP_RETI = 4'd4,  OP_WAIT = 4'd5,  OP_PSHA = 4'd6,  OP_PSHB = 4'd7,
        OP_PSHX = 4'd8,  OP_PSHY = 4'd9,  OP_PULA = 4'd10, OP_PULB = 4'd11,
        OP_PULX = 4'd12, OP_PULY = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_PARK = 2'd2
    } state_e;

    typedef struct packed {
        logic              ok;    // legal command
        logic              push;  // 1 = save, 0 = restore
        logic [SLOT_W-1:0] base;  // first slot of the run
        logic [SLOT_W-1:0] len;   // number of bytes
        logic              park;  // hold for irq after save
        logic              vec;   // request vector on completion
    } plan_t;

    typedef logic [FRAME_BYTES-1:0][BYTE_W-1:0] frame_t;

    function automatic plan_t mk_plan(logic push, logic [SLOT_W-1:0] base,
                                      logic [SLOT_W-1:0] len, logic park, logic vec);
        plan_t p;
        p.ok   = 1'b1;
        p.push = push;
        p.base = base;
        p.len  = len;
        p.park = park;
        p.vec  = vec;
        return p;
    endfunction

    function automatic plan_t plan_of(logic [3:0] code);
        plan_t p;
        p = '0;
        case (op_e'(code))
            OP_CALL: p = mk_plan(1'b1, SL_RET_LO, 4'd2, 1'b0, 1'b0);
            OP_RETS: p = mk_plan(1'b0, SL_RET_LO, 4'd2, 1'b0, 1'b0);
            OP_INTR: p = mk_plan(1'b1, SL_RET_LO, 4'd9, 1'b0, 1'b1);
            OP_RETI: p = mk_plan(1'b0, SL_RET_LO, 4'd9, 1'b0, 1'b0);
            OP_WAIT: p = mk_plan(1'b1, SL_RET_LO, 4'd9, 1'b1, 1'b1);
            OP_PSHA: p = mk_plan(1'b1, SL_A,      4'd1, 1'b0, 1'b0);
            OP_PSHB: p = mk_plan(1'b1, SL_B,      4'd1, 1'b0, 1'b0);
            OP_PSHX: p = mk_plan(1'b1, SL_IX_LO,  4'd2, 1'b0, 1'b0);
            OP_PSHY: p = mk_plan(1'b1, SL_IY_LO,  4'd2, 1'b0, 1'b0);
            OP_PULA: p = mk_plan(1'b0, SL_A,      4'd1, 1'b0, 1'b0);
            OP_PULB: p = mk_plan(1'b0, SL_B,      4'd1, 1'b0, 1'b0);
            OP_PULX: p = mk_plan(1'b0, SL_IX_LO,  4'd2, 1'b0, 1'b0);
            OP_PULY: p = mk_plan(1'b0, SL_IY_LO,  4'd2, 1'b0, 1'b0);
            default: p = '0;
        endcase
        return p;
    endfunction

    // slot touched by the k-th access: saves run upward, restores downward
    function automatic logic [SLOT_W-1:0] slot_at(plan_t p, logic [SLOT_W-1:0] k);
        if (p.push) return p.base + k;
        return p.base + p.len - 4'd1 - k;
    endfunction

endpackage

// File: rtl/ctx_cmd_decode.sv
module ctx_cmd_decode
    import ctx_stack_pkg::*;
(
    input  logic [3:0] code,
    output plan_t      plan
);
    always_comb plan = plan_of(code);
endmodule

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_SP = 'h00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_dn,
    input  logic              step_up,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_above
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    assign sp_above = sp + ONE;

    always_ff @(posedge clk) begin
        if (rst)          sp <= RESET_SP;
        else if (step_dn) sp <= sp - ONE;
        else if (step_up) sp <= sp_above;
    end
endmodule

// File: rtl/ctx_restore_bank.sv
module ctx_restore_bank
    import ctx_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [SLOT_W-1:0] cap_slot,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic              commit,
    input  logic [SLOT_W-1:0] run_base,
    input  logic [SLOT_W-1:0] run_len,
    output frame_t            shown
);
    frame_t    shadow;
    logic [SLOT_W:0] run_end;

    assign run_end = {1'b0, run_base} + {1'b0, run_len};

    for (genvar i = 0; i < FRAME_BYTES; i++) begin : g_slot
        localparam logic [SLOT_W:0] MY = (SLOT_W+1)'(i);
        logic hit, in_run;
        assign hit    = cap_en && ({1'b0, cap_slot} == MY);
        assign in_run = ({1'b0, run_base} <= MY) && (MY < run_end);

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i] <= '0;
                shown[i]  <= '0;
            end else begin
                if (hit) shadow[i] <= cap_byte;
                if (commit && in_run) shown[i] <= hit ? cap_byte : shadow[i];
            end
        end
    end
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_stack_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_SP = 'h00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [15:0]       ret_addr_in,
    input  logic [15:0]       ix_in,
    input  logic [15:0]       iy_in,
    input  logic [7:0]        acca_in,
    input  logic [7:0]        accb_in,
    input  logic [7:0]        ccr_in,
    input  logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              done,
    output logic              vec_req,
    output logic [ADDR_W-1:0] sp_out,
    output logic [15:0]       ret_addr_out,
    output logic [15:0]       ix_out,
    output logic [15:0]       iy_out,
    output logic [7:0]        acca_out,
    output logic [7:0]        accb_out,
    output logic [7:0]        ccr_out
);
    state_e            state;
    plan_t             plan_d, plan_q;
    logic [SLOT_W-1:0] idx_q, slot_cur;
    frame_t            save_buf, shown;
    logic              done_q, vec_q;
    logic              accept, fire, last;
    logic [ADDR_W-1:0] sp, sp_above;

    ctx_cmd_decode u_dec (.code(cmd_op), .plan(plan_d));

    assign accept   = (state == ST_IDLE) && cmd_valid && plan_d.ok;
    assign fire     = (state == ST_XFER) && mem_gnt;
    assign last     = (idx_q == plan_q.len - 4'd1);
    assign slot_cur = slot_at(plan_q, idx_q);

    ctx_sp_unit #(.ADDR_W(ADDR_W), .RESET_SP(RESET_SP)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .step_dn  (fire && plan_q.push),
        .step_up  (fire && !plan_q.push),
        .sp       (sp),
        .sp_above (sp_above)
    );

    ctx_restore_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (fire && !plan_q.push),
        .cap_slot (slot_cur),
        .cap_byte (mem_rdata),
        .commit   (fire && !plan_q.push && last),
        .run_base (plan_q.base),
        .run_len  (plan_q.len),
        .shown    (shown)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            plan_q   <= '0;
            idx_q    <= '0;
            save_buf <= '0;
            done_q   <= 1'b0;
            vec_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            vec_q  <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_XFER;
                    plan_q   <= plan_d;
                    idx_q    <= '0;
                    save_buf <= {ccr_in, accb_in, acca_in,
                                 ix_in[15:8], ix_in[7:0],
                                 iy_in[15:8], iy_in[7:0],
                                 ret_addr_in[15:8], ret_addr_in[7:0]};
                end
                ST_XFER: if (mem_gnt) begin
                    if (last) begin
                        state  <= plan_q.park ? ST_PARK : ST_IDLE;
                        done_q <= !plan_q.park;
                        vec_q  <= plan_q.vec && !plan_q.park;
                    end else begin
                        idx_q <= idx_q + 4'd1;
                    end
                end
                ST_PARK: if (irq) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    vec_q  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_XFER);
    assign mem_we    = mem_req && plan_q.push;
    assign mem_addr  = plan_q.push ? sp : sp_above;
    assign mem_wdata = save_buf[slot_cur];

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign vec_req = vec_q;
    assign sp_out  = sp;

    assign ret_addr_out = {shown[1], shown[0]};
    assign iy_out       = {shown[3], shown[2]};
    assign ix_out       = {shown[5], shown[4]};
    assign acca_out     = shown[6];
    assign accb_out     = shown[7];
    assign ccr_out      = shown[8];
endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              vec_req,
    input logic [ADDR_W-1:0] sp_out,
    input logic [15:0]       ret_addr_out,
    input logic [15:0]       ix_out,
    input logic [15:0]       iy_out,
    input logic [7:0]        acca_out,
    input logic [7:0]        accb_out,
    input logic [7:0]        ccr_out
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    p_write_at_sp_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr == sp_out);

    p_read_above_sp_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> mem_addr == sp_out + ONE);

    p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt && mem_we |=> sp_out == $past(sp_out) - ONE);

    p_pull_step_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt && !mem_we |=> sp_out == $past(sp_out) + ONE);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(sp_out) && $stable(mem_addr));

    p_req_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_outputs_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(ret_addr_out) && $stable(ix_out) &&
        $stable(iy_out) && $stable(acca_out) && $stable(accb_out) && $stable(ccr_out));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_vec_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> done);

    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind ctx_stack_seq ctx_stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .busy(busy), .done(done), .vec_req(vec_req),
    .sp_out(sp_out), .ret_addr_out(ret_addr_out), .ix_out(ix_out), .iy_out(iy_out),
    .acca_out(acca_out), .accb_out(accb_out), .ccr_out(ccr_out)
);

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOG_N      = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        cmd_valid = 0, cmd_valid_w = 0, irq = 0;
    logic [3:0]  cmd_op = 0;
    logic [15:0] ret_in = 0, ix_in = 0, iy_in = 0;
    logic [7:0]  a_in = 0, b_in = 0, c_in = 0;
    logic        gnt_en = 1, alt_gnt = 0;
    logic [31:0] cyc = 0;

    logic        mem_req, mem_we, mem_gnt, busy, done, vec_req;
    logic [15:0] mem_addr, sp, ret_out, ix_out, iy_out;
    logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, c_out;

    logic        req_w, we_w, busy_w, done_w, vec_w;
    logic [15:0] addr_w, sp_w, ret_w, ix_w, iy_w;
    logic [7:0]  wd_w, rd_w, a_w, b_w, c_w;

    logic [7:0]  mem   [256];
    logic [7:0]  mem_w [256];
    logic [15:0] log_addr [LOG_N];
    logic [7:0]  log_data [LOG_N];
    logic        log_we   [LOG_N];
    int          log_n = 0;

    int n_chk = 0, n_bad = 0;

    assign mem_gnt   = gnt_en && (!alt_gnt || cyc[0]);
    assign mem_rdata = mem[mem_addr[7:0]];
    assign rd_w      = mem_w[addr_w[7:0]];

    ctx_stack_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .ret_addr_in(ret_in), .ix_in(ix_in), .iy_in(iy_in),
        .acca_in(a_in), .accb_in(b_in), .ccr_in(c_in), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .busy(busy), .done(done), .vec_req(vec_req), .sp_out(sp),
        .ret_addr_out(ret_out), .ix_out(ix_out), .iy_out(iy_out),
        .acca_out(a_out), .accb_out(b_out), .ccr_out(c_out)
    );

    ctx_stack_seq #(.ADDR_W(16), .RESET_SP(16'h0001)) uut_wrap (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid_w), .cmd_op(cmd_op),
        .ret_addr_in(ret_in), .ix_in(ix_in), .iy_in(iy_in),
        .acca_in(a_in), .accb_in(b_in), .ccr_in(c_in), .irq(1'b0),
        .mem_req(req_w), .mem_we(we_w), .mem_addr(addr_w),
        .mem_wdata(wd_w), .mem_rdata(rd_w), .mem_gnt(1'b1),
        .busy(busy_w), .done(done_w), .vec_req(vec_w), .sp_out(sp_w),
        .ret_addr_out(ret_w), .ix_out(ix_w), .iy_out(iy_w),
        .acca_out(a_w), .accb_out(b_w), .ccr_out(c_w)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            log_addr[log_n % LOG_N] <= mem_addr;
            log_data[log_n % LOG_N] <= mem_we ? mem_wdata : mem_rdata;
            log_we[log_n % LOG_N]   <= mem_we;
            log_n <= log_n + 1;
        end
        if (req_w && we_w) mem_w[addr_w[7:0]] <= wd_w;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got cycle %0d expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // byte of the save frame for slot k, per the R3 order
    function automatic logic [7:0] frame_byte(int k, logic [15:0] r, logic [15:0] y,
                                              logic [15:0] x, logic [7:0] a,
                                              logic [7:0] b, logic [7:0] c);
        case (k)
            0: return r[7:0];  1: return r[15:8];
            2: return y[7:0];  3: return y[15:8];
            4: return x[7:0];  5: return x[15:8];
            6: return a;       7: return b;
            default: return c;
        endcase
    endfunction

    task automatic issue(input logic [3:0] op);
        @(negedge clk); cmd_op = op; cmd_valid = 1;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic issue_w(input logic [3:0] op);
        @(negedge clk); cmd_op = op; cmd_valid_w = 1;
        @(negedge clk); cmd_valid_w = 0;
    endtask

    task automatic wait_done(output logic vec_seen);
        vec_seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin vec_seen = vec_req; return; end
            @(negedge clk);
        end
        chk("R11", "done never seen", 0, 1);
    endtask

    task automatic wait_done_w();
        for (int i = 0; i < 200; i++) begin
            if (done_w) return;
            @(negedge clk);
        end
        chk("R10", "wrap instance done never seen", 0, 1);
    endtask

    task automatic t_reset();
        chk("R10", "reset SP", sp, 16'h00FF);
        chk("R10", "reset SP of wrap instance", sp_w, 16'h0001);
        chk("R7", "reset busy", busy, 0);
        chk("R6", "reset mem_req", mem_req, 0);
        chk("R9", "reset restored return", ret_out, 0);
    endtask

    task automatic t_ignored_codes();
        int base = log_n;
        issue(4'd0); issue(4'd14); issue(4'd15);
        repeat (3) @(negedge clk);
        chk("R12", "busy after non-commands", busy, 0);
        chk("R12", "SP after non-commands", sp, 16'h00FF);
        chk("R12", "accesses after non-commands", log_n - base, 0);
    endtask

    task automatic t_call();
        int base; logic v;
        ret_in = 16'h1234;
        base = log_n;
        issue(4'd1);
        wait_done(v);
        chk("R11", "call-save vec_req", v, 0);
        chk("R1", "call-save accesses", log_n - base, 2);
        chk("R1", "first write addr", log_addr[base], 16'h00FF);
        chk("R1", "first write byte", log_data[base], 8'h34);
        chk("R1", "second write addr", log_addr[base+1], 16'h00FE);
        chk("R1", "second write byte", log_data[base+1], 8'h12);
        chk("R1", "SP after call-save", sp, 16'h00FD);
        @(negedge clk);
        chk("R11", "done lasts one cycle", done, 0);
    endtask

    task automatic t_return();
        int base; logic v;
        ret_in = 16'hFFFF;
        base = log_n;
        issue(4'd2);
        wait_done(v);
        chk("R2", "return read addr 1", log_addr[base], 16'h00FE);
        chk("R2", "return read addr 2", log_addr[base+1], 16'h00FF);
        chk("R2", "return is read", log_we[base], 0);
        chk("R2", "restored return", ret_out, 16'h1234);
        chk("R2", "SP after call-restore", sp, 16'h00FF);
    endtask

    task automatic t_stall();
        int base; logic v;
        gnt_en = 0;
        ret_in = 16'hA55A;
        base = log_n;
        issue(4'd1);
        repeat (4) begin
            @(negedge clk);
            chk("R6", "request held while stalled", mem_req, 1);
            chk("R6", "address held while stalled", mem_addr, 16'h00FF);
            chk("R6", "SP held while stalled", sp, 16'h00FF);
        end
        chk("R6", "no access while stalled", log_n - base, 0);
        gnt_en = 1;
        wait_done(v);
        chk("R6", "SP after stalled call-save", sp, 16'h00FD);
        issue(4'd2);
        wait_done(v);
        chk("R6", "return after stall", ret_out, 16'hA55A);
    endtask

    task automatic t_interrupt();
        int base; logic v;
        ret_in = 16'hC0DE; iy_in = 16'h2233; ix_in = 16'h4455;
        a_in = 8'h66; b_in = 8'h77; c_in = 8'h88;
        alt_gnt = 1;
        base = log_n;
        issue(4'd3);
        chk("R7", "busy after accept", busy, 1);
        cmd_op = 4'd1; cmd_valid = 1;
        ret_in = 16'h0BAD; a_in = 8'h00;
        repeat (2) @(negedge clk);
        cmd_valid = 0;
        wait_done(v);
        alt_gnt = 0;
        chk("R3", "vec_req with done", v, 1);
        chk("R7", "only the frame written", log_n - base, 9);
        for (int k = 0; k < 9; k++) begin
            chk("R3", "frame write addr", log_addr[base+k], 16'h00FF - 16'(k));
            chk("R3", "frame write byte", log_data[base+k],
                frame_byte(k, 16'hC0DE, 16'h2233, 16'h4455, 8'h66, 8'h77, 8'h88));
        end
        chk("R3", "SP after interrupt-save", sp, 16'h00F6);
        @(negedge clk);
        chk("R7", "ignored command left SP", sp, 16'h00F6);
    endtask

    task automatic t_reti();
        int base;
        logic [15:0] r0;
        r0 = ret_out;
        ret_in = 16'h0; ix_in = 16'h0; iy_in = 16'h0;
        base = log_n;
        issue(4'd4);
        for (int i = 0; i < 40 && !done; i++) begin
            chk("R9", "return held during restore", ret_out, r0);
            @(negedge clk);
        end
        chk("R4", "frame read count", log_n - base, 9);
        for (int k = 0; k < 9; k++)
            chk("R4", "reverse read addr", log_addr[base+k], 16'h00F7 + 16'(k));
        chk("R4", "restored ccr", c_out, 8'h88);
        chk("R4", "restored B", b_out, 8'h77);
        chk("R4", "restored A", a_out, 8'h66);
        chk("R4", "restored X", ix_out, 16'h4455);
        chk("R4", "restored Y", iy_out, 16'h2233);
        chk("R4", "restored return", ret_out, 16'hC0DE);
        chk("R4", "SP after interrupt-restore", sp, 16'h00FF);
        chk("R11", "no vec on restore", vec_req, 0);
    endtask

    task automatic t_single();
        int base; logic v;
        a_in = 8'h5A; ix_in = 16'hBEEF;
        base = log_n;
        issue(4'd6); wait_done(v);
        issue(4'd8); wait_done(v);
        chk("R5", "A byte", log_data[base], 8'h5A);
        chk("R5", "X low at SP", log_addr[base+1], 16'h00FE);
        chk("R5", "X low byte", log_data[base+1], 8'hEF);
        chk("R5", "X high byte", log_data[base+2], 8'hBE);
        chk("R5", "SP after single saves", sp, 16'h00FC);
        issue(4'd12); wait_done(v);
        chk("R5", "X high read first", log_addr[base+3], 16'h00FD);
        chk("R5", "restored X", ix_out, 16'hBEEF);
        chk("R5", "Y untouched by X restore", iy_out, 16'h2233);
        issue(4'd10); wait_done(v);
        chk("R5", "restored A", a_out, 8'h5A);
        chk("R5", "B untouched by A restore", b_out, 8'h77);
        chk("R5", "SP after single restores", sp, 16'h00FF);
    endtask

    task automatic t_wait();
        int base; logic v;
        ret_in = 16'h7001; iy_in = 16'h1122; ix_in = 16'h3344;
        a_in = 8'h55; b_in = 8'h66; c_in = 8'hC4;
        base = log_n;
        issue(4'd5);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) chk("R8", "done while parked", done, 0);
        end
        chk("R8", "saved bytes before irq", log_n - base, 9);
        chk("R8", "still busy", busy, 1);
        chk("R8", "no request while parked", mem_req, 0);
        chk("R8", "SP after wait save", sp, 16'h00F6);
        irq = 1;
        @(negedge clk);
        irq = 0;
        chk("R8", "done after irq", done, 1);
        chk("R8", "vec_req after irq", vec_req, 1);
        chk("R8", "no extra writes", log_n - base, 9);
        @(negedge clk);
        issue(4'd4); wait_done(v);
        chk("R8", "frame from wait restores", ret_out, 16'h7001);
        chk("R8", "ccr from wait restores", c_out, 8'hC4);
    endtask

    task automatic t_wrap();
        ret_in = 16'h9ABC;
        issue_w(4'd1); wait_done_w();
        chk("R10", "SP wraps below zero", sp_w, 16'hFFFF);
        issue_w(4'd3); wait_done_w();
        chk("R10", "SP after frame at top", sp_w, 16'hFFF6);
        issue_w(4'd4); wait_done_w();
        chk("R10", "SP after frame restore", sp_w, 16'hFFFF);
        issue_w(4'd2); wait_done_w();
        chk("R10", "SP wraps above top", sp_w, 16'h0001);
        chk("R10", "return across wrap", ret_w, 16'h9ABC);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; mem_w[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ignored_codes();
        t_call();
        t_return();
        t_stall();
        t_interrupt();
        t_reti();
        t_single();
        t_wait();
        t_wrap();
        summary();
        $finish;
    end
endmodule